// File: doc/BRIEF.md
# Pipelined 5x5 Window Kurtosis Engine

The engine takes a square window of 25 unsigned 8-bit samples and returns the kurtosis of those samples as an unsigned fixed-point number. Kurtosis here is the fourth central moment divided by the square of the second central moment. Every sample's deviation, square and fourth power is formed at the same time. The sums feed a pipelined divider, so the engine accepts a new window on every clock and returns each result a fixed number of cycles later. Two independent lanes are built side by side by default, so two windows go in and two results come out per clock. A boundary finder would use it by streaming neighbourhoods from an unwrapped image and thresholding the results downstream.

The mean is never divided out. Each deviation is taken as 25 times the sample minus the window sum, which is an exact integer. The common scale factors cancel in the ratio, so the only rounding in the whole datapath is the final truncation of the quotient. A window whose samples are all equal has zero spread. For such a window the lane reports a saturated value and raises a flag instead of dividing by zero.

Top module: `kurtosis_unit`

## Requirements
- R1: After reset, out_valid, out_kurt and out_flat are all zero until a window has travelled through the pipeline.
- R2: Every clock edge that samples in_valid high produces exactly one result, with out_valid high 18 edges later (5 moment stages plus one per quotient bit). Windows on consecutive cycles give results on consecutive cycles, in order, and out_valid is low in every other cycle.
- R3: For a window that is not flat, the lane result equals floor(256 * 25 * S4 / S2^2). Here S2 and S4 are the sums of the squared and fourth-power deviations from the window mean. The result is a 13-bit unsigned value with 8 fractional bits, so it lies at most 1/256 below the real-valued kurtosis.
- R4: Lane l takes its window from in_win[200*l +: 200], and sample k of that window sits at bits [8*k +: 8]. Reordering the samples inside a window does not change the result.
- R5: When all 25 samples of a lane are equal, that lane's out_flat bit is 1 and its out_kurt field is 8191 (all ones).
- R6: For a window that is not flat, the lane's out_flat bit is 0 and its result lies in the range 256 (kurtosis 1.0) up to, but not including, 6400 (kurtosis 25.0).
- R7: The two lanes work independently in the same cycle. Lane l reports in out_kurt[13*l +: 13] and out_flat[l], and its result depends only on its own window.
- R8: Adding the same offset to every sample of a window, without overflow, leaves the result unchanged.
- R9: A window with 24 equal samples and one different sample gives 5898 (553/24 truncated to 8 fractional bits), whatever the two sample values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_win in this cycle |
| in_win | input | 400 | Two 25-sample windows of 8-bit samples, lane 0 in the low half |
| out_valid | output | 1 | Qualifies out_kurt and out_flat |
| out_kurt | output | 26 | Per-lane kurtosis, unsigned 5.8 fixed point |
| out_flat | output | 2 | Per-lane zero-spread flag |

## Verification
The engine is driven with random windows on back-to-back cycles and with sparse windows separated by idle gaps. Together these separate a correct fixed latency from stalls, bubbles and reordering. Flat windows at the extreme sample values exercise the zero-spread path. A two-level window and single-outlier windows pin exact quotients near the lower and upper ends of the range, which exposes any truncation or width error in the divider. Pairs of windows that differ by an offset, by a permutation of the samples or by a lane swap must give identical results. This shows that the mean really is removed, that sample order does not matter and that the lanes do not interfere with each other.

// File: rtl/kurt_pkg.sv
package kurt_pkg;

  // number of bits needed to count 0..n
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

  // signed width of a scaled deviation n*x - sum(x)
  function automatic int dev_width(input int n, input int pix_w);
    return pix_w + cnt_width(n) + 1;
  endfunction

  function automatic int m2_width(input int n, input int pix_w);
    return 2 * dev_width(n, pix_w) + cnt_width(n);
  endfunction

  function automatic int m4_width(input int n, input int pix_w);
    return 4 * dev_width(n, pix_w) + cnt_width(n);
  endfunction

  function automatic int num_width(input int n, input int pix_w, input int frac_w);
    return m4_width(n, pix_w) + cnt_width(n) + frac_w;
  endfunction

  function automatic int den_width(input int n, input int pix_w);
    return 2 * m2_width(n, pix_w);
  endfunction

  // deviation scaled by the window size: exact, no fractional mean needed
  function automatic logic signed [31:0] scaled_dev(input logic [31:0] n,
                                                    input logic [31:0] x,
                                                    input logic [31:0] total);
    return $signed(n * x) - $signed(total);
  endfunction

endpackage

// File: rtl/kurt_moments.sv
module kurt_moments
  import kurt_pkg::*;
#(
  parameter int N_PIX  = 25,
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8,
  localparam int CNT_W = cnt_width(N_PIX),
  localparam int WIN_W = N_PIX * PIX_W,
  localparam int NUM_W = num_width(N_PIX, PIX_W, FRAC_W),
  localparam int DEN_W = den_width(N_PIX, PIX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIN_W-1:0] in_win,
  output logic             mo_valid,
  output logic [NUM_W-1:0] mo_num,
  output logic [DEN_W-1:0] mo_den,
  output logic             mo_zero
);

  localparam int SUM_W = PIX_W + CNT_W;
  localparam int DEV_W = dev_width(N_PIX, PIX_W);
  localparam int SQ_W  = 2 * DEV_W;
  localparam int Q4_W  = 4 * DEV_W;
  localparam int M2_W  = m2_width(N_PIX, PIX_W);
  localparam int M4_W  = m4_width(N_PIX, PIX_W);
  localparam int BAL_W = DEV_W + CNT_W;

  // stage 1: window sum
  logic [SUM_W-1:0] sum_c, s1_sum;
  logic [WIN_W-1:0] s1_win;
  logic             s1_v;

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < N_PIX; i++)
      sum_c = sum_c + SUM_W'(in_win[i*PIX_W +: PIX_W]);
  end

  // stage 2: scaled deviations and their squares, all samples at once
  logic signed [DEV_W-1:0] dev_c   [N_PIX];
  logic        [SQ_W-1:0]  sq_c    [N_PIX];
  logic        [SQ_W-1:0]  s2_sq   [N_PIX];
  logic signed [BAL_W-1:0] dev_sum;
  logic                    s2_v;

  always_comb begin
    logic signed [31:0]     dv;
    logic signed [SQ_W-1:0] ext;
    dev_sum = '0;
    for (int i = 0; i < N_PIX; i++) begin
      dv       = scaled_dev(32'(N_PIX), 32'(s1_win[i*PIX_W +: PIX_W]), 32'(s1_sum));
      dev_c[i] = dv[DEV_W-1:0];
      ext      = SQ_W'(dev_c[i]);
      sq_c[i]  = ext * ext;
      dev_sum  = dev_sum + BAL_W'(dev_c[i]);
    end
  end

  // stage 3: fourth powers by squaring the squares, second-moment sum
  logic [Q4_W-1:0] q4_c  [N_PIX];
  logic [Q4_W-1:0] s3_q4 [N_PIX];
  logic [M2_W-1:0] m2_c, s3_m2;
  logic            s3_v;

  always_comb begin
    logic [Q4_W-1:0] qa;
    m2_c = '0;
    for (int i = 0; i < N_PIX; i++) begin
      qa      = Q4_W'(s2_sq[i]);
      q4_c[i] = qa * qa;
      m2_c    = m2_c + M2_W'(s2_sq[i]);
    end
  end

  // stage 4: fourth-moment sum
  logic [M4_W-1:0] m4_c, s4_m4;
  logic [M2_W-1:0] s4_m2;
  logic            s4_v;

  always_comb begin
    m4_c = '0;
    for (int i = 0; i < N_PIX; i++)
      m4_c = m4_c + M4_W'(s3_q4[i]);
  end

  // stage 5: dividend N*S4 scaled by 2^FRAC_W, divisor S2^2
  logic [NUM_W-1:0] num_c;
  logic [DEN_W-1:0] den_c;
  assign num_c = (NUM_W'(s4_m4) * NUM_W'(N_PIX)) << FRAC_W;
  assign den_c = DEN_W'(s4_m2) * DEN_W'(s4_m2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s2_v     <= 1'b0;
      s3_v     <= 1'b0;
      s4_v     <= 1'b0;
      mo_valid <= 1'b0;
    end else begin
      s1_v     <= in_valid;
      s2_v     <= s1_v;
      s3_v     <= s2_v;
      s4_v     <= s3_v;
      mo_valid <= s4_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_win <= in_win;
    s1_sum <= sum_c;
    for (int i = 0; i < N_PIX; i++) begin
      s2_sq[i] <= sq_c[i];
      s3_q4[i] <= q4_c[i];
    end
    s3_m2   <= m2_c;
    s4_m4   <= m4_c;
    s4_m2   <= s3_m2;
    mo_num  <= num_c;
    mo_den  <= den_c;
    mo_zero <= (s4_m2 == '0);
  end

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= '0;
    else if (warm != 3'd5)  warm <= warm + 3'd1;
  end

  AST_DEV_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> (dev_sum == '0)); // R3

  AST_MOMENT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd5) |-> (mo_valid == $past(in_valid, 5))); // R2

endmodule

// File: rtl/kurt_divider.sv
module kurt_divider #(
  parameter int NUM_W = 74,
  parameter int DEN_W = 66,
  parameter int QW    = 13,
  localparam int CW   = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + QW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NUM_W-1:0] in_num,
  input  logic [DEN_W-1:0] in_den,
  input  logic             in_zero,
  output logic             out_valid,
  output logic [QW-1:0]    out_q,
  output logic             out_zero
);

  // one restoring step per quotient bit, MSB first
  logic             st_v   [QW];
  logic [NUM_W-1:0] st_rem [QW];
  logic [DEN_W-1:0] st_den [QW];
  logic [QW-1:0]    st_q   [QW];
  logic             st_z   [QW];

  logic             cur_v   [QW];
  logic [NUM_W-1:0] cur_rem [QW];
  logic [DEN_W-1:0] cur_den [QW];
  logic [QW-1:0]    cur_q   [QW];
  logic             cur_z   [QW];
  logic [CW-1:0]    den_sh  [QW];
  logic [NUM_W-1:0] nxt_rem [QW];
  logic             nxt_bit [QW];

  always_comb begin
    logic [CW-1:0] rem_x;
    for (int j = 0; j < QW; j++) begin
      if (j == 0) begin
        cur_v[j]   = in_valid;
        cur_rem[j] = in_num;
        cur_den[j] = in_den;
        cur_q[j]   = '0;
        cur_z[j]   = in_zero;
      end else begin
        cur_v[j]   = st_v[j-1];
        cur_rem[j] = st_rem[j-1];
        cur_den[j] = st_den[j-1];
        cur_q[j]   = st_q[j-1];
        cur_z[j]   = st_z[j-1];
      end
      den_sh[j] = CW'(cur_den[j]) << (QW - 1 - j);
      rem_x     = CW'(cur_rem[j]);
      if (rem_x >= den_sh[j]) begin
        nxt_rem[j] = NUM_W'(rem_x - den_sh[j]);
        nxt_bit[j] = 1'b1;
      end else begin
        nxt_rem[j] = cur_rem[j];
        nxt_bit[j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < QW; j++) st_v[j] <= 1'b0;
    end else begin
      for (int j = 0; j < QW; j++) st_v[j] <= cur_v[j];
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < QW; j++) begin
      st_rem[j] <= nxt_rem[j];
      st_den[j] <= cur_den[j];
      st_q[j]   <= {cur_q[j][QW-2:0], nxt_bit[j]};
      st_z[j]   <= cur_z[j];
    end
  end

  assign out_valid = st_v[QW-1];
  assign out_q     = st_q[QW-1];
  assign out_zero  = st_z[QW-1];

  AST_DIV_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v[QW-1] && (st_den[QW-1] != '0)) |->
      (CW'(st_rem[QW-1]) < CW'(st_den[QW-1]))); // R3

endmodule

// File: rtl/kurtosis_unit.sv
module kurtosis_unit
  import kurt_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int SIDE   = 5,
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8,
  localparam int N_PIX = SIDE * SIDE,
  localparam int CNT_W = cnt_width(N_PIX),
  localparam int QW    = CNT_W + FRAC_W,
  localparam int WIN_W = N_PIX * PIX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*WIN_W-1:0] in_win,
  output logic                   out_valid,
  output logic [LANES*QW-1:0]    out_kurt,
  output logic [LANES-1:0]       out_flat
);

  localparam int NUM_W = num_width(N_PIX, PIX_W, FRAC_W);
  localparam int DEN_W = den_width(N_PIX, PIX_W);

  logic [LANES-1:0] lane_v;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             mv, mz, dv, dz;
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;
    logic [QW-1:0]    dq;
    logic [QW-1:0]    kq_r;
    logic             flat_r;

    kurt_moments #(.N_PIX(N_PIX), .PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_mom (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_win   (in_win[l*WIN_W +: WIN_W]),
      .mo_valid (mv),
      .mo_num   (num),
      .mo_den   (den),
      .mo_zero  (mz)
    );

    kurt_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QW(QW)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (mv),
      .in_num    (num),
      .in_den    (den),
      .in_zero   (mz),
      .out_valid (dv),
      .out_q     (dq),
      .out_zero  (dz)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kq_r   <= '0;
        flat_r <= 1'b0;
      end else if (dv) begin
        kq_r   <= dz ? '1 : dq;
        flat_r <= dz;
      end
    end

    assign lane_v[l]                = dv;
    assign out_kurt[l*QW +: QW]     = kq_r;
    assign out_flat[l]              = flat_r;

    AST_KURT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !flat_r) |->
        ((kq_r >= QW'(1 << FRAC_W)) && (kq_r < QW'(N_PIX << FRAC_W)))); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= lane_v[0];
  end

  AST_LANE_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    lane_v == {LANES{lane_v[0]}}); // R7

endmodule

// File: tb/kurtosis_unit_bench.sv
`timescale 1ns/1ps
module kurtosis_unit_bench;
  localparam int LANES = 2;
  localparam int NPIX  = 25;
  localparam int PW    = 8;
  localparam int WW    = NPIX * PW;
  localparam int QW    = 13;
  localparam int LAT   = 18;
  localparam int MAXW  = 512;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   in_valid = 1'b0;
  logic [LANES*WW-1:0]    in_win = '0;
  logic                   out_valid;
  logic [LANES*QW-1:0]    out_kurt;
  logic [LANES-1:0]       out_flat;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent_cnt = 0;
  int got_cnt = 0;
  logic [LANES*WW-1:0] sent_win [MAXW];
  int                  sent_at  [MAXW];
  int                  got_k    [MAXW][LANES];
  int                  got_f    [MAXW][LANES];

  kurtosis_unit u_kurtosis_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win),
    .out_valid(out_valid), .out_kurt(out_kurt), .out_flat(out_flat)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real kurt_model(input logic [WW-1:0] w);
    real s = 0.0, mu, d, m2 = 0.0, m4 = 0.0;
    for (int k = 0; k < NPIX; k++) s += real'(w[k*PW +: PW]);
    mu = s / NPIX;
    for (int k = 0; k < NPIX; k++) begin
      d = real'(w[k*PW +: PW]) - mu;
      m2 += d * d;
      m4 += d * d * d * d;
    end
    return NPIX * m4 / (m2 * m2);
  endfunction

  function automatic bit is_flat(input logic [WW-1:0] w);
    for (int k = 1; k < NPIX; k++)
      if (w[k*PW +: PW] != w[7:0]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [WW-1:0] const_win(input int v);
    logic [WW-1:0] w;
    for (int k = 0; k < NPIX; k++) w[k*PW +: PW] = PW'(v);
    return w;
  endfunction

  function automatic logic [WW-1:0] rand_win(input int lo, input int hi);
    logic [WW-1:0] w;
    for (int k = 0; k < NPIX; k++) w[k*PW +: PW] = PW'($urandom_range(hi, lo));
    return w;
  endfunction

  function automatic logic [WW-1:0] rev_win(input logic [WW-1:0] w);
    logic [WW-1:0] r;
    for (int k = 0; k < NPIX; k++) r[k*PW +: PW] = w[(NPIX-1-k)*PW +: PW];
    return r;
  endfunction

  function automatic logic [WW-1:0] offset_win(input logic [WW-1:0] w, input int off);
    logic [WW-1:0] r;
    for (int k = 0; k < NPIX; k++) r[k*PW +: PW] = w[k*PW +: PW] + PW'(off);
    return r;
  endfunction

  task automatic send(input logic [LANES*WW-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_win   = w;
    sent_win[sent_cnt] = w;
    sent_at[sent_cnt]  = cyc + 1;
    sent_cnt++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (got_cnt < sent_cnt) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard: timing, flag and value of every result against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (got_cnt >= sent_cnt) begin
          chk(1'b0, "R2", "result without a window", 1, 0);
        end else begin
          chk(cyc == sent_at[got_cnt] + LAT, "R2", "result cycle", cyc, sent_at[got_cnt] + LAT);
          for (int l = 0; l < LANES; l++) begin
            logic [WW-1:0] w;
            int  k;
            real kq;
            w = sent_win[got_cnt][l*WW +: WW];
            k = int'(out_kurt[l*QW +: QW]);
            got_k[got_cnt][l] = k;
            got_f[got_cnt][l] = int'(out_flat[l]);
            if (is_flat(w)) begin
              chk(out_flat[l] == 1'b1, "R5", "flat flag", int'(out_flat[l]), 1);
              chk(k == 8191, "R5", "flat saturation", k, 8191);
            end else begin
              kq = kurt_model(w) * 256.0;
              chk(out_flat[l] == 1'b0, "R6", "flag on spread window", int'(out_flat[l]), 0);
              chk(k >= 256 && k < 6400, "R6", "range", k, 256);
              chk((real'(k) <= kq + 1e-6) && (real'(k) > kq - 1.0 - 1e-6),
                  "R3", "kurtosis vs model", k, int'(kq));
            end
          end
          got_cnt++;
        end
      end else if (got_cnt < sent_cnt && cyc == sent_at[got_cnt] + LAT) begin
        chk(1'b0, "R2", "missing result", 0, 1);
      end
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    idle(5);
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    chk(out_kurt == '0, "R1", "kurt after reset", int'(out_kurt), 0);
    chk(out_flat == '0, "R1", "flat after reset", int'(out_flat), 0);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) send({rand_win(0, 255), rand_win(i, i + 60)});
    drain();
    chk(got_cnt == sent_cnt, "R2", "stream count", got_cnt, sent_cnt);
  endtask

  task automatic t_gaps();
    int base = sent_cnt;
    for (int i = 0; i < 8; i++) begin
      send({rand_win(20, 40), rand_win(0, 255)});
      idle(i % 4);
    end
    drain();
    chk(got_cnt - base == 8, "R2", "gapped count", got_cnt - base, 8);
  endtask

  task automatic t_flat();
    int base = sent_cnt;
    send({const_win(255), const_win(0)});
    send({rand_win(0, 255), const_win(77)});
    drain();
    chk(got_f[base][0] == 1 && got_f[base][1] == 1, "R5", "both lanes flat", got_f[base][1], 1);
    chk(got_k[base+1][0] == 8191, "R5", "flat lane 0", got_k[base+1][0], 8191);
    chk(got_f[base+1][1] == 0, "R7", "lane 1 unaffected by flat lane 0", got_f[base+1][1], 0);
  endtask

  task automatic t_outlier();
    int base = sent_cnt;
    logic [WW-1:0] a, b;
    a = const_win(0);   a[7*PW +: PW]  = 8'd200;
    b = const_win(50);  b[24*PW +: PW] = 8'd3;
    send({b, a});
    drain();
    chk(got_k[base][0] == 5898, "R9", "outlier lane 0", got_k[base][0], 5898);
    chk(got_k[base][1] == 5898, "R9", "outlier lane 1", got_k[base][1], 5898);
  endtask

  task automatic t_two_level();
    int base = sent_cnt;
    logic [WW-1:0] a;
    for (int k = 0; k < NPIX; k++) a[k*PW +: PW] = (k < 12) ? 8'd10 : 8'd90;
    send({rev_win(a), a});
    drain();
    chk(got_k[base][0] == 257, "R3", "two-level exact", got_k[base][0], 257);
    chk(got_k[base][1] == 257, "R4", "two-level reversed", got_k[base][1], 257);
  endtask

  task automatic t_offset();
    int base = sent_cnt;
    logic [WW-1:0] a, b;
    a = rand_win(0, 100);
    b = rand_win(0, 150);
    send({b, a});
    send({offset_win(b, 105), offset_win(a, 155)});
    drain();
    chk(got_k[base+1][0] == got_k[base][0], "R8", "offset lane 0", got_k[base+1][0], got_k[base][0]);
    chk(got_k[base+1][1] == got_k[base][1], "R8", "offset lane 1", got_k[base+1][1], got_k[base][1]);
  endtask

  task automatic t_permute();
    int base = sent_cnt;
    logic [WW-1:0] a, b;
    a = rand_win(0, 255);
    b = rand_win(30, 90);
    send({b, a});
    send({rev_win(a), b});
    drain();
    chk(got_k[base+1][1] == got_k[base][0], "R4", "reordered window", got_k[base+1][1], got_k[base][0]);
    chk(got_k[base+1][0] == got_k[base][1], "R7", "lane swap", got_k[base+1][0], got_k[base][1]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_gaps();
    t_flat();
    t_outlier();
    t_two_level();
    t_offset();
    t_permute();
    idle(LAT + 4);
    chk(got_cnt == sent_cnt, "R2", "final count", got_cnt, sent_cnt);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule